// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This combinational block sits at the end of instruction decode. It takes the opcode and funct3 fields of the current instruction, the current program counter, two register operands and an immediate that has already been sign-extended. From these it produces the address of the next instruction. For conditional branches it evaluates six compare conditions, covering equality and both signed and unsigned ordering. For both kinds of unconditional jump it also produces the value to write back as the return address.

Instructions that are not control transfers fall through to PC+4 and raise no flag. An encoding that sits in a control-transfer opcode but has no defined meaning raises the illegal flag. In that case the next PC stays sequential and no link write is requested. The control class of each instruction is held as an enumerated type (sequential, branch, PC-relative jump, register-based jump), chosen in one unique case over the opcode. All address arithmetic is modulo 2^XLEN.

Top module: `bnj_nextpc`

## Requirements
- R1: The opcode sits in instruction bits [6:0] and funct3 in bits [14:12]. With opcode 0x63, funct3 0 is taken when the operands are equal, and funct3 1 is taken when they differ.
- R2: With opcode 0x63, funct3 4 is taken when operand 1 is less than operand 2 as two's-complement numbers. Funct3 5 is taken when operand 1 is greater than or equal to operand 2 under the same signed compare.
- R3: With opcode 0x63, funct3 6 is taken when operand 1 is below operand 2 as unsigned numbers. Funct3 7 is taken when operand 1 is at or above operand 2 as unsigned numbers.
- R4: A taken branch sets next_pc to PC+imm and raises taken. A branch that is not taken sets next_pc to PC+4 with taken low. No branch ever raises link_we.
- R5: Opcode 0x6f raises taken and link_we and sets next_pc to PC+imm.
- R6: Opcode 0x67 with funct3 0 raises taken and link_we. Its next_pc is rs1+imm with bit 0 forced to zero.
- R7: The following raise illegal: opcode 0x63 with funct3 2 or 3, and opcode 0x67 with any nonzero funct3. Each of these gives next_pc = PC+4 with taken and link_we low.
- R8: Any other opcode gives next_pc = PC+4 with taken, link_we and illegal all low.
- R9: The sequential address and the targets wrap modulo 2^XLEN.
- R10: Whenever link_we is high, link_val equals PC+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 7 | Instruction bits [6:0] |
| funct3_i | input | 3 | Instruction bits [14:12] |
| pc_i | input | XLEN | Address of the current instruction |
| rs1_i | input | XLEN | First register operand |
| rs2_i | input | XLEN | Second register operand |
| imm_i | input | XLEN | Sign-extended immediate |
| next_pc_o | output | XLEN | Address of the next instruction |
| taken_o | output | 1 | Control leaves the sequential path |
| link_we_o | output | 1 | Return address must be written |
| link_val_o | output | XLEN | Return address value |
| illegal_o | output | 1 | Undefined control-transfer encoding |

## Verification
The bound checker tests the relations between outputs on every input change:
- a taken output never comes with illegal;
- link_we implies both taken and link_val = PC+4;
- an output that is not taken or is illegal always yields PC+4;
- a register-based jump never yields an odd target.

Whether each of the six compare conditions picks the right answer at signed and unsigned extremes can only be shown by the bench's vectors. The same holds for the exact target sums and for wrap-around at the top of the address space.

// File: rtl/bnj_pkg.sv
package bnj_pkg;

    localparam logic [6:0] OPC_BRANCH = 7'h63;
    localparam logic [6:0] OPC_JAL    = 7'h6f;
    localparam logic [6:0] OPC_JALR   = 7'h67;

    // Control class of the instruction being resolved
    typedef enum logic [1:0] {
        CLS_SEQ      = 2'd0,
        CLS_BRANCH   = 2'd1,
        CLS_JUMP_REL = 2'd2,
        CLS_JUMP_REG = 2'd3
    } ctl_cls_e;

    typedef struct packed {
        ctl_cls_e cls;
        logic     illegal;
    } dec_t;

endpackage

// File: rtl/bnj_decode.sv
module bnj_decode
    import bnj_pkg::*;
(
    input  logic [6:0] opcode,
    input  logic [2:0] funct3,
    output dec_t       dec
);

    always_comb begin
        dec.cls     = CLS_SEQ;
        dec.illegal = 1'b0;
        unique case (opcode)
            OPC_BRANCH: begin
                // funct3 values 2 and 3 carry no compare
                if (funct3[2:1] == 2'b01) dec.illegal = 1'b1;
                else                      dec.cls     = CLS_BRANCH;
            end
            OPC_JAL: begin
                dec.cls = CLS_JUMP_REL;
            end
            OPC_JALR: begin
                if (funct3 == 3'd0) dec.cls     = CLS_JUMP_REG;
                else                dec.illegal = 1'b1;
            end
            default: begin
                dec.cls = CLS_SEQ;
            end
        endcase
    end

endmodule

// File: rtl/bnj_cond.sv
module bnj_cond #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [2:0]      funct3,
    output logic            hold
);

    localparam int MSB = XLEN - 1;

    logic eq, lt_u, lt_s, base;

    always_comb begin
        eq   = (a == b);
        lt_u = (a < b);
        // differing signs decide the signed order directly
        lt_s = (a[MSB] != b[MSB]) ? a[MSB] : lt_u;
        // bit 2: ordering vs equality, bit 1: unsigned, bit 0: invert
        if (funct3[2]) base = funct3[1] ? lt_u : lt_s;
        else           base = eq;
        hold = base ^ funct3[0];
    end

endmodule

// File: rtl/bnj_target.sv
module bnj_target #(
    parameter int XLEN      = 64,
    parameter bit CLEAR_LSB = 1'b1
) (
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] rs1,
    input  logic [XLEN-1:0] imm,
    input  logic            use_reg,
    output logic [XLEN-1:0] target
);

    logic [XLEN-1:0] sum;

    // one shared adder, base chosen ahead of it
    assign sum = (use_reg ? rs1 : pc) + imm;

    generate
        if (CLEAR_LSB) begin : g_clr
            assign target = use_reg ? {sum[XLEN-1:1], 1'b0} : sum;
        end else begin : g_raw
            assign target = sum;
        end
    endgenerate

endmodule

// File: rtl/bnj_nextpc.sv
module bnj_nextpc
    import bnj_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int INSN_BYTES = 4
) (
    input  logic [6:0]      opcode_i,
    input  logic [2:0]      funct3_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] rs1_i,
    input  logic [XLEN-1:0] rs2_i,
    input  logic [XLEN-1:0] imm_i,
    output logic [XLEN-1:0] next_pc_o,
    output logic            taken_o,
    output logic            link_we_o,
    output logic [XLEN-1:0] link_val_o,
    output logic            illegal_o
);

    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    dec_t            dec;
    logic            cond_hold;
    logic [XLEN-1:0] target;
    logic [XLEN-1:0] seq_pc;
    logic            take;
    logic            link;

    bnj_decode u_dec (
        .opcode (opcode_i),
        .funct3 (funct3_i),
        .dec    (dec)
    );

    bnj_cond #(.XLEN(XLEN)) u_cond (
        .a      (rs1_i),
        .b      (rs2_i),
        .funct3 (funct3_i),
        .hold   (cond_hold)
    );

    bnj_target #(.XLEN(XLEN), .CLEAR_LSB(1'b1)) u_tgt (
        .pc      (pc_i),
        .rs1     (rs1_i),
        .imm     (imm_i),
        .use_reg (dec.cls == CLS_JUMP_REG),
        .target  (target)
    );

    assign seq_pc = pc_i + STEP;

    always_comb begin
        unique case (dec.cls)
            CLS_SEQ:      begin take = 1'b0;      link = 1'b0; end
            CLS_BRANCH:   begin take = cond_hold; link = 1'b0; end
            CLS_JUMP_REL: begin take = 1'b1;      link = 1'b1; end
            CLS_JUMP_REG: begin take = 1'b1;      link = 1'b1; end
            default:      begin take = 1'b0;      link = 1'b0; end
        endcase
    end

    assign next_pc_o  = take ? target : seq_pc;
    assign taken_o    = take;
    assign link_we_o  = link;
    assign link_val_o = seq_pc;
    assign illegal_o  = dec.illegal;

endmodule

// File: rtl/bnj_nextpc_chk.sv
module bnj_nextpc_chk #(
    parameter int XLEN = 64
) (
    input  logic [6:0]      opcode_i,
    input  logic [2:0]      funct3_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] next_pc_o,
    input  logic            taken_o,
    input  logic            link_we_o,
    input  logic [XLEN-1:0] link_val_o,
    input  logic            illegal_o
);

    localparam logic [XLEN-1:0] FOUR = XLEN'(4);

    always_comb begin
        // R7: an illegal encoding never transfers control
        assert_illegal_not_taken_R7: assert (!(illegal_o && taken_o))
            else $error("illegal with taken");
        // R7, R8, R4: every non-taken outcome is sequential
        if (!taken_o) begin
            assert_fallthrough_R4: assert (next_pc_o == pc_i + FOUR)
                else $error("non-taken next_pc not sequential");
        end
        // R10: link value is the return address
        if (link_we_o) begin
            assert_link_value_R10: assert (link_val_o == pc_i + FOUR)
                else $error("link value wrong");
            assert_link_implies_taken_R5: assert (taken_o)
                else $error("link without taken");
        end
        // R6: register-based jump target is even
        if (opcode_i == 7'h67 && funct3_i == 3'd0) begin
            assert_jalr_even_R6: assert (next_pc_o[0] == 1'b0)
                else $error("odd register jump target");
        end
    end

endmodule

bind bnj_nextpc bnj_nextpc_chk #(.XLEN(XLEN)) u_chk (
    .opcode_i   (opcode_i),
    .funct3_i   (funct3_i),
    .pc_i       (pc_i),
    .next_pc_o  (next_pc_o),
    .taken_o    (taken_o),
    .link_we_o  (link_we_o),
    .link_val_o (link_val_o),
    .illegal_o  (illegal_o)
);

// File: tb/sim_bnj_nextpc.sv
`timescale 1ns/1ps
module sim_bnj_nextpc;

    localparam int XLEN = 64;
    localparam logic [63:0] MINV = 64'h8000_0000_0000_0000;
    localparam logic [63:0] MAXV = 64'h7fff_ffff_ffff_ffff;
    localparam logic [63:0] ONES = 64'hffff_ffff_ffff_ffff;
    localparam logic [63:0] PCB  = 64'h1000;
    localparam logic [63:0] TGT  = 64'h1020;
    localparam logic [63:0] SEQ  = 64'h1004;

    typedef struct packed {
        logic [3:0]  req;
        logic [6:0]  op;
        logic [2:0]  f3;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] imm;
        logic [63:0] nxt;
        logic        tk;
        logic        we;
        logic        il;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{4'd1, 7'h63, 3'd0, 64'd5, 64'd5, 64'h20, TGT, 1'b1, 1'b0, 1'b0}, // R1 beq equal
        '{4'd1, 7'h63, 3'd0, 64'd5, 64'd6, 64'h20, SEQ, 1'b0, 1'b0, 1'b0}, // R1 beq differ
        '{4'd1, 7'h63, 3'd1, 64'd5, 64'd6, 64'h20, TGT, 1'b1, 1'b0, 1'b0}, // R1 bne differ
        '{4'd1, 7'h63, 3'd1, ONES,  ONES,  64'h20, SEQ, 1'b0, 1'b0, 1'b0}, // R1 bne equal
        '{4'd2, 7'h63, 3'd4, ONES,  64'd0, 64'h20, TGT, 1'b1, 1'b0, 1'b0}, // R2 -1 < 0
        '{4'd2, 7'h63, 3'd4, MINV,  MAXV,  64'h20, TGT, 1'b1, 1'b0, 1'b0}, // R2 min < max
        '{4'd2, 7'h63, 3'd4, MAXV,  MINV,  64'h20, SEQ, 1'b0, 1'b0, 1'b0}, // R2 max !< min
        '{4'd2, 7'h63, 3'd5, MINV,  MINV,  64'h20, TGT, 1'b1, 1'b0, 1'b0}, // R2 ge equal
        '{4'd2, 7'h63, 3'd5, ONES,  64'd0, 64'h20, SEQ, 1'b0, 1'b0, 1'b0}, // R2 -1 !>= 0
        '{4'd3, 7'h63, 3'd6, 64'd0, ONES,  64'h20, TGT, 1'b1, 1'b0, 1'b0}, // R3 0 < max
        '{4'd3, 7'h63, 3'd6, ONES,  64'd0, 64'h20, SEQ, 1'b0, 1'b0, 1'b0}, // R3
        '{4'd3, 7'h63, 3'd6, MINV,  MAXV,  64'h20, SEQ, 1'b0, 1'b0, 1'b0}, // R3 msb set is larger
        '{4'd3, 7'h63, 3'd7, ONES,  ONES,  64'h20, TGT, 1'b1, 1'b0, 1'b0}, // R3 geu equal
        '{4'd3, 7'h63, 3'd7, MAXV,  MINV,  64'h20, SEQ, 1'b0, 1'b0, 1'b0}, // R3
        '{4'd7, 7'h63, 3'd2, 64'd1, 64'd1, 64'h20, SEQ, 1'b0, 1'b0, 1'b1}, // R7 funct3 2
        '{4'd7, 7'h63, 3'd3, 64'd0, ONES,  64'h20, SEQ, 1'b0, 1'b0, 1'b1}, // R7 funct3 3
        '{4'd5, 7'h6f, 3'd0, 64'd0, 64'd0, 64'hffff_ffff_ffff_fff8, 64'h0ff8, 1'b1, 1'b1, 1'b0}, // R5 backward
        '{4'd6, 7'h67, 3'd0, 64'h2001, 64'd0, 64'h10, 64'h2010, 1'b1, 1'b1, 1'b0}, // R6
        '{4'd6, 7'h67, 3'd0, 64'h3000, 64'd0, 64'h7, 64'h3006, 1'b1, 1'b1, 1'b0},  // R6 odd sum
        '{4'd7, 7'h67, 3'd1, 64'h3000, 64'd0, 64'h10, SEQ, 1'b0, 1'b0, 1'b1},      // R7 jalr f3
        '{4'd8, 7'h13, 3'd0, 64'd5, 64'd5, 64'h20, SEQ, 1'b0, 1'b0, 1'b0}          // R8 other op
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [6:0]      opcode_i = 7'h00;
    logic [2:0]      funct3_i = 3'd0;
    logic [XLEN-1:0] pc_i = PCB;
    logic [XLEN-1:0] rs1_i = '0;
    logic [XLEN-1:0] rs2_i = '0;
    logic [XLEN-1:0] imm_i = '0;
    logic [XLEN-1:0] next_pc_o;
    logic            taken_o;
    logic            link_we_o;
    logic [XLEN-1:0] link_val_o;
    logic            illegal_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bnj_nextpc #(.XLEN(XLEN), .INSN_BYTES(4)) u0 (
        .opcode_i   (opcode_i),
        .funct3_i   (funct3_i),
        .pc_i       (pc_i),
        .rs1_i      (rs1_i),
        .rs2_i      (rs2_i),
        .imm_i      (imm_i),
        .next_pc_o  (next_pc_o),
        .taken_o    (taken_o),
        .link_we_o  (link_we_o),
        .link_val_o (link_val_o),
        .illegal_o  (illegal_o)
    );

    task automatic apply(input logic [6:0] op, input logic [2:0] f3,
                         input logic [63:0] pc, input logic [63:0] a,
                         input logic [63:0] b, input logic [63:0] imm);
        @(negedge clk);
        opcode_i = op; funct3_i = f3; pc_i = pc;
        rs1_i = a; rs2_i = b; imm_i = imm;
        #1;
    endtask

    task automatic expect_out(input int req, input logic [63:0] nxt,
                              input logic tk, input logic we, input logic il,
                              input logic [63:0] lnk);
        n_chk++;
        if (next_pc_o !== nxt || taken_o !== tk || link_we_o !== we ||
            illegal_o !== il || (we && link_val_o !== lnk)) begin
            n_fail++;
            $display("FAIL R%0d: got next=%h tk=%b we=%b il=%b link=%h, exp next=%h tk=%b we=%b il=%b link=%h",
                     req, next_pc_o, taken_o, link_we_o, illegal_o, link_val_o,
                     nxt, tk, we, il, lnk);
        end
    endtask

    initial begin
        // reset state: inputs idle, outputs sequential (R8)
        repeat (3) @(posedge clk);
        #1;
        expect_out(8, SEQ, 1'b0, 1'b0, 1'b0, SEQ);
        rst_n = 1'b1;

        // table walk: R1 R2 R3 R4 R5 R6 R7 R8, link checked per R10
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].op, VECS[i].f3, PCB, VECS[i].a, VECS[i].b, VECS[i].imm);
            expect_out(int'(VECS[i].req), VECS[i].nxt, VECS[i].tk,
                       VECS[i].we, VECS[i].il, SEQ);
        end

        // R9: sequential wrap at the top of the address space
        apply(7'h13, 3'd0, 64'hffff_ffff_ffff_fffc, 64'd0, 64'd0, 64'd0);
        expect_out(9, 64'd0, 1'b0, 1'b0, 1'b0, 64'd0);
        // R9: PC-relative jump wraps, link wraps too (R10)
        apply(7'h6f, 3'd0, 64'hffff_ffff_ffff_fff0, 64'd0, 64'd0, 64'h20);
        expect_out(9, 64'h10, 1'b1, 1'b1, 1'b0, 64'hffff_ffff_ffff_fff4);
        // R6: all-ones sum loses its low bit
        apply(7'h67, 3'd0, PCB, 64'd0, 64'd0, ONES);
        expect_out(6, 64'hffff_ffff_ffff_fffe, 1'b1, 1'b1, 1'b0, SEQ);
        // R4: taken branch does not link, backward target
        apply(7'h63, 3'd0, 64'h8000, 64'd0, 64'd0, 64'hffff_ffff_ffff_ff00);
        expect_out(4, 64'h7f00, 1'b1, 1'b0, 1'b0, 64'h8004);
        // R2 vs R3: same operands, signed and unsigned disagree
        apply(7'h63, 3'd5, PCB, 64'd0, ONES, 64'h20);
        expect_out(2, TGT, 1'b1, 1'b0, 1'b0, SEQ);
        apply(7'h63, 3'd7, PCB, 64'd0, ONES, 64'h20);
        expect_out(3, SEQ, 1'b0, 1'b0, 1'b0, SEQ);
        // R7: largest jalr funct3
        apply(7'h67, 3'd7, PCB, 64'h40, 64'd0, 64'h20);
        expect_out(7, SEQ, 1'b0, 1'b0, 1'b1, SEQ);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, exp completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule